// File: doc/BRIEF.md
# Clock-Stuck-High Watchdog for a Two-Wire Target Interface

This block sits beside the receiving engine of a two-wire management bus (SMBus/PMBus style) on the target side. It samples the raw clock and data lines and tracks whether a message is in progress. A message begins at a start condition and ends at a stop condition. While a message is in progress it measures how long the clock line has been high without a break. If that time reaches 50 ms, the block treats the clock as stuck. It then sets a sticky status flag and emits a one-cycle abort pulse, which returns the protocol engine to idle to wait for a new start. The status flag also drives an interrupt request, gated by an active-low mask.

The watchdog is armed through a single control bit, written with a strobe. A build-time parameter chooses the sense of that bit. In the enable variant the bit resets to 0 and arms the watchdog when it is 1. In the disable variant the bit resets to 1 and arms the watchdog when it is 0. Recovery needs no software polling.

Top module: `scl_hold_watchdog`

## Requirements
- R1: After reset, `stat_flag`, `irq` and `abort_pulse` are 0, and the control bit holds its variant default (0 when `EN_POL_HIGH`=1, 1 when `EN_POL_HIGH`=0). In both variants the default leaves the watchdog unarmed.
- R2: Both lines pass through a two-flop synchronizer. A start is the synchronized data falling while the synchronized clock is high. A stop is the synchronized data rising while the synchronized clock is high. Clock-high time outside a message never causes a timeout.
- R3: The terminal count is LIMIT = (CLK_HZ/1000)*TIMEOUT_MS cycles. When armed, a data fall with the clock held high makes `abort_pulse` rise on exactly the (LIMIT+3)-th rising system-clock edge after the input change.
- R4: A synchronized clock-low sample restarts the count. A clock that goes low before LIMIT high cycles have passed never times out.
- R5: A stop ends the message. The clock may then stay high indefinitely without a timeout.
- R6: `abort_pulse` is high for exactly one cycle. The message then counts as ended, so no further timeout occurs until a new start.
- R7: `stat_flag` is set together with the abort pulse. It stays set until a `stat_clr` strobe, which clears it on the next edge. If a clear and a timeout fall on the same edge, the flag ends up set.
- R8: `irq` is 1 exactly when `stat_flag` is 1 and `irq_mask` is 0.
- R9: A `ctl_wr` strobe loads `ctl_wdata` into the control bit. The watchdog is armed when the bit is 1 (`EN_POL_HIGH`=1) or 0 (`EN_POL_HIGH`=0). While unarmed, the count is held at zero, so a later arming counts a full LIMIT from the arming edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| ctl_wr | input | 1 | Write strobe for the arming control bit |
| ctl_wdata | input | 1 | Value loaded into the control bit |
| irq_mask | input | 1 | Interrupt mask, 1 blocks the request |
| stat_clr | input | 1 | One-cycle clear of the status flag |
| stat_flag | output | 1 | Sticky clock-high-timeout status |
| irq | output | 1 | Interrupt request |
| abort_pulse | output | 1 | One-cycle return-to-idle command for the protocol engine |

## Verification
The bench runs one instance of each polarity variant from the same control bus. Each write therefore arms one instance and disarms the other, and one instance is required to stay silent while the other fires. The abort edge is checked at its exact cycle after the synchronizer delay. A counter that is off by one, or that ignores the synchronizer, fails that check. A long idle-high stretch and a post-stop stretch catch a counter that runs outside messages. A clock toggled just short of the limit catches a count that never resets on a low sample. The bench also holds the clock high long after an abort, which exposes a design that forgets to end the message and fires again. It lands a clear on the same edge as a timeout, which exposes the wrong priority. Finally it arms an instance in the middle of a message, which catches a count that kept running while the watchdog was unarmed.

// File: rtl/scl_hold_watchdog.sv
module scl_hold_watchdog #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int TIMEOUT_MS  = 50,
  parameter bit EN_POL_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic ctl_wr,
  input  logic ctl_wdata,
  input  logic irq_mask,
  input  logic stat_clr,
  output logic stat_flag,
  output logic irq,
  output logic abort_pulse
);

  localparam int LIMIT = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic CTL_RST = EN_POL_HIGH ? 1'b0 : 1'b1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [1:0]    scl_sy;
  logic [2:0]    sda_sy;
  logic          ctl_bit;
  logic          busy;
  logic [CW-1:0] cnt;

  wire scl_h   = scl_sy[1];
  wire start   = scl_h & sda_sy[2] & ~sda_sy[1];
  wire stop    = scl_h & ~sda_sy[2] & sda_sy[1];
  wire armed   = EN_POL_HIGH ? ctl_bit : ~ctl_bit;
  wire counting = armed & busy & scl_h & ~start & ~stop;
  wire hit     = counting & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_bit <= CTL_RST;
    else if (ctl_wr) ctl_bit <= ctl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy <= 1'b0;
    else if (start)            busy <= 1'b1;
    else if (stop || hit)      busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!counting || hit) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_pulse <= 1'b0;
      stat_flag   <= 1'b0;
    end else begin
      abort_pulse <= hit;
      stat_flag   <= hit | (stat_flag & ~stat_clr);
    end
  end

  assign irq = stat_flag & ~irq_mask;

  a_r6_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);
  a_r6_message_ended: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> !busy);
  a_r7_flag_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> stat_flag);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flag && !stat_clr) |=> stat_flag);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !abort_pulse);
  a_r9_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (!abort_pulse && cnt == '0));
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: tb/scl_hold_watchdog_bench.sv
module scl_hold_watchdog_bench;
  localparam int CLK_HZ = 2000;
  localparam int TMS = 50;
  localparam int LIMIT = (CLK_HZ / 1000) * TMS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic ctl_wr = 1'b0, ctl_wdata = 1'b0, irq_mask = 1'b1, stat_clr = 1'b0;
  logic a_stat, a_irq, a_abort, b_stat, b_irq, b_abort;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  scl_hold_watchdog #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TMS), .EN_POL_HIGH(1'b1)) u_scl_hold_watchdog (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .irq_mask(irq_mask), .stat_clr(stat_clr),
    .stat_flag(a_stat), .irq(a_irq), .abort_pulse(a_abort));

  scl_hold_watchdog #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TMS), .EN_POL_HIGH(1'b0)) u_scl_hold_watchdog_alt (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .irq_mask(irq_mask), .stat_clr(stat_clr),
    .stat_flag(b_stat), .irq(b_irq), .abort_pulse(b_abort));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic go_idle();
    scl = 1'b1; sda = 1'b1; step(4);
  endtask

  task automatic write_ctl(input logic v);
    ctl_wr = 1'b1; ctl_wdata = v; step(1); ctl_wr = 1'b0;
  endtask

  task automatic clear_stat();
    stat_clr = 1'b1; step(1); stat_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 a stat", a_stat, 1'b0);
    chk("R1 a abort", a_abort, 1'b0);
    chk("R1 b stat", b_stat, 1'b0);
    chk("R1 b irq", b_irq, 1'b0);
  endtask

  task automatic t_unarmed();
    go_idle();
    sda = 1'b0; step(LIMIT + 30);
    chk("R9 reset default unarmed a", a_stat, 1'b0);
    chk("R9 reset default unarmed b", b_stat, 1'b0);
    go_idle();
  endtask

  task automatic t_idle_high();
    write_ctl(1'b1);
    go_idle(); step(3 * LIMIT);
    chk("R2 idle high no timeout", a_stat, 1'b0);
  endtask

  task automatic t_exact_timeout();
    go_idle();
    sda = 1'b0; step(LIMIT + 2);
    chk("R3 no abort one edge early", a_abort, 1'b0);
    step(1);
    chk("R3 abort on LIMIT+3 edge", a_abort, 1'b1);
    chk("R7 flag set with abort", a_stat, 1'b1);
    chk("R9 disarmed variant silent", b_abort, 1'b0);
    step(1);
    chk("R6 abort one cycle", a_abort, 1'b0);
    irq_mask = 1'b1; #1;
    chk("R8 irq masked", a_irq, 1'b0);
    irq_mask = 1'b0; #1;
    chk("R8 irq unmasked", a_irq, 1'b1);
    chk("R9 b stat still clear", b_stat, 1'b0);
    for (int i = 0; i < 3 * LIMIT; i++) begin
      step(1);
      if (a_abort) begin chk("R6 no second abort", a_abort, 1'b0); break; end
    end
    chk("R7 flag sticky", a_stat, 1'b1);
    clear_stat();
    chk("R7 clear strobe", a_stat, 1'b0);
    chk("R8 irq follows flag", a_irq, 1'b0);
    irq_mask = 1'b1;
    go_idle();
  endtask

  task automatic t_keepalive();
    go_idle();
    sda = 1'b0; step(LIMIT - 10);
    for (int k = 0; k < 4; k++) begin
      scl = 1'b0; step(2); sda = k[0]; step(1); scl = 1'b1; step(LIMIT - 10);
    end
    chk("R4 low samples restart count", a_stat, 1'b0);
    scl = 1'b0; step(2); sda = 1'b0; step(2); scl = 1'b1; step(2); sda = 1'b1;
    step(3 * LIMIT);
    chk("R5 no timeout after stop", a_stat, 1'b0);
  endtask

  task automatic t_set_wins();
    go_idle();
    sda = 1'b0; step(LIMIT + 2);
    stat_clr = 1'b1; step(1); stat_clr = 1'b0;
    chk("R7 abort at clear edge", a_abort, 1'b1);
    chk("R7 set beats clear", a_stat, 1'b1);
    go_idle();
    clear_stat();
    chk("R7 cleared afterwards", a_stat, 1'b0);
  endtask

  task automatic t_arm_midway();
    go_idle();
    sda = 1'b0; step(LIMIT - 10);
    write_ctl(1'b0);
    step(LIMIT - 1);
    chk("R9 b fresh count not early", b_abort, 1'b0);
    step(1);
    chk("R9 b abort LIMIT after arming", b_abort, 1'b1);
    chk("R9 a disarmed midway", a_stat, 1'b0);
    step(1);
    chk("R6 b abort one cycle", b_abort, 1'b0);
    go_idle();
  endtask

  initial begin
    step(3); rst_n = 1'b1; step(1);
    t_reset();
    t_unarmed();
    t_idle_high();
    t_exact_timeout();
    t_keepalive();
    t_set_wins();
    t_arm_midway();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule